// File: doc/BRIEF.md
# Board Initialisation Sequencer

This block steps a board through its start-up and recovery actions under command. While idle it takes a four-bit target-state code from a configuration register each time a take-action strobe rises. It then runs that action: a timed active-low reset pulse to the timing receiver, the link serialiser, the JTAG test-reset lines or the front-end chips; a wait for configuration PROM load or for serialiser PLL lock; a clock-manager reset; or a phase-sampling step. After the action it returns to idle, or moves on by itself to the next state in its chain.

After power-up, and whenever the FPGA-reset command is given, the sequencer runs the receiver reset path and then the serialiser reset path with no further command. A configuration flag chooses whether the receiver reset path waits for a PROM load before the clock-manager reset. A failed phase-sampling step raises an error bit. A retry command clears that bit once the fault has gone. While the fault remains, the retry command runs the sampling step again. The outside chips, the clock manager and the phase sampler appear only as done and lock inputs. Every pulse width and the PLL wait limit are parameters counted in 40 MHz clocks.

Top module: `board_init_seq`

## Requirements
- R1: `state_code` shows the current state: 0 idle, 1 FPGA reset, 2 receiver reset, 3 serialiser reset, 4 PLL-lock wait, 5 clock-manager reset, 6 phase sampling, 7 JTAG reset, 8 receiver reset with PROM load, 9 front-end reset, 10 PROM wait, 11 error retry. At most one of the five reset outputs is active at any time.
- R2: In idle, a rising edge on `cmd_go` moves the state to `cmd_code` on the next clock edge. A rising edge in any other state has no effect.
- R3: In idle, command codes 0 and 12 to 15 leave the state at idle.
- R4: Receiver reset drives `rcv_rst_n` low for exactly RCV_RST_CYC cycles (16 by default). It then goes to PROM wait when `use_prom` is 1, or to clock-manager reset when `use_prom` is 0.
- R5: PROM wait holds until `prom_done` is 1 and then goes to clock-manager reset. Clock-manager reset drives `clkmgr_rst` high for CLK_RST_CYC cycles (4 by default). It leaves when that count has passed and `clk_locked` is 1, so with the lock present it lasts CLK_RST_CYC+1 cycles.
- R6: Serialiser reset drives `ser_rst_n` low for exactly SER_RST_CYC cycles (16 by default) and then goes to PLL-lock wait.
- R7: PLL-lock wait returns to idle on the cycle after `pll_lock` is seen high. Without the lock it returns after LOCK_WAIT_CYC cycles.
- R8: JTAG reset holds `trst_n` low for TRST_CYC cycles (14 by default). Front-end reset holds `fe_rst_n` low for FE_RST_CYC cycles (32 by default). Both then return to idle.
- R9: Receiver reset with PROM load drives `rcv_rst_n` low for RCV_RST_CYC cycles and then always goes to PROM wait, whatever `use_prom` is.
- R10: After reset, and after the one-cycle FPGA-reset state, the receiver reset path runs. On leaving clock-manager reset it continues to serialiser reset, then PLL-lock wait, then idle.
- R11: Phase sampling drives `phase_req` high until `phase_done` is 1 and then goes to idle. If `phase_ok` is 0 on that cycle, `err_flag` is set. A successful sample does not clear the flag.
- R12: Error retry lasts one cycle. If `err_flag` is 1 and `phase_ok` is 0, it goes to phase sampling and keeps the flag. Otherwise it goes to idle and clears the flag.
- R13: Holding `cmd_go` high gives exactly one transition out of idle.
- R14: While `rst_n` is low, the state is receiver reset, `rcv_rst_n` is 0, the other resets are inactive and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_code | input | 4 | Requested target state |
| cmd_go | input | 1 | Take-action strobe, rising-edge sensitive |
| use_prom | input | 1 | Configuration flag selecting the PROM-load path |
| prom_done | input | 1 | PROM load finished |
| clk_locked | input | 1 | Clock manager locked |
| pll_lock | input | 1 | Serialiser PLL locked |
| phase_done | input | 1 | Phase sampler finished |
| phase_ok | input | 1 | Phase sampler reports no fault |
| rcv_rst_n | output | 1 | Timing receiver reset, active low |
| ser_rst_n | output | 1 | Link serialiser reset, active low |
| trst_n | output | 1 | JTAG test-reset lines, active low |
| fe_rst_n | output | 1 | Front-end chip reset, active low |
| clkmgr_rst | output | 1 | Clock-manager reset, active high |
| phase_req | output | 1 | Phase sampling request |
| state_code | output | 4 | Current state code |
| err_flag | output | 1 | Phase-sampling error bit |

## Verification
The state register moves on the first clock edge after the edge that sees a rising strobe or a done or lock input. All outputs decode the state register directly, so each result shows up one cycle after its cause. A timed state lasts exactly its width parameter: the dwell counter starts at zero on entry, and the state leaves on the edge after the count reaches width minus one. Clock-manager reset stays one cycle longer because it must see the lock after its pulse. The bench changes inputs and samples outputs on falling edges. It counts falling edges while a state holds, so each dwell is compared with its parameter as an exact cycle count.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_FPGA_RST  = 4'd1,
    ST_RCV_RST   = 4'd2,
    ST_SER_RST   = 4'd3,
    ST_LOCK_WAIT = 4'd4,
    ST_CLK_RST   = 4'd5,
    ST_PHASE     = 4'd6,
    ST_TRST      = 4'd7,
    ST_RCV_LOAD  = 4'd8,
    ST_FE_RST    = 4'd9,
    ST_PROM_WAIT = 4'd10,
    ST_ERR_RETRY = 4'd11
  } state_e;

  // Commands above the last defined state map onto idle (R3).
  function automatic state_e decode_cmd(input logic [3:0] code);
    if (code <= 4'd11) return state_e'(code);
    return ST_IDLE;
  endfunction

  // True on the final cycle of a dwell of len cycles.
  function automatic logic at_last(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_strobe_edge.sv
module init_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/init_dwell_timer.sv
module init_dwell_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/init_next_state.sv
module init_next_state
  import init_seq_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int RCV_RST_CYC  = 16,
  parameter int SER_RST_CYC  = 16,
  parameter int TRST_CYC     = 14,
  parameter int FE_RST_CYC   = 32,
  parameter int CLK_RST_CYC  = 4,
  parameter int LOCK_WAIT_CYC = 40
) (
  input  state_e           state,
  input  logic [CNT_W-1:0] cnt,
  input  logic             go_rise,
  input  logic [3:0]       cmd_code,
  input  logic             use_prom,
  input  logic             chain,
  input  logic             err,
  input  logic             prom_done,
  input  logic             clk_locked,
  input  logic             pll_lock,
  input  logic             phase_done,
  input  logic             phase_ok,
  output state_e           nxt,
  output logic             set_err,
  output logic             clr_err,
  output logic             set_chain,
  output logic             clr_chain
);
  int unsigned c;
  assign c = 32'(cnt);

  always_comb begin
    nxt       = state;
    set_err   = 1'b0;
    clr_err   = 1'b0;
    set_chain = 1'b0;
    clr_chain = 1'b0;
    case (state)
      ST_IDLE:      if (go_rise) nxt = decode_cmd(cmd_code);
      ST_FPGA_RST:  begin nxt = ST_RCV_RST; set_chain = 1'b1; end
      ST_RCV_RST:   if (at_last(c, RCV_RST_CYC))
                      nxt = use_prom ? ST_PROM_WAIT : ST_CLK_RST;
      ST_RCV_LOAD:  if (at_last(c, RCV_RST_CYC)) nxt = ST_PROM_WAIT;
      ST_PROM_WAIT: if (prom_done) nxt = ST_CLK_RST;
      ST_CLK_RST:   if (c >= CLK_RST_CYC && clk_locked) begin
                      if (chain) begin nxt = ST_SER_RST; clr_chain = 1'b1; end
                      else nxt = ST_IDLE;
                    end
      ST_SER_RST:   if (at_last(c, SER_RST_CYC)) nxt = ST_LOCK_WAIT;
      ST_LOCK_WAIT: if (pll_lock || at_last(c, LOCK_WAIT_CYC)) nxt = ST_IDLE;
      ST_PHASE:     if (phase_done) begin
                      nxt = ST_IDLE;
                      set_err = ~phase_ok;
                    end
      ST_TRST:      if (at_last(c, TRST_CYC)) nxt = ST_IDLE;
      ST_FE_RST:    if (at_last(c, FE_RST_CYC)) nxt = ST_IDLE;
      ST_ERR_RETRY: if (err && !phase_ok) nxt = ST_PHASE;
                    else begin nxt = ST_IDLE; clr_err = err; end
      default:      nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/board_init_seq.sv
module board_init_seq
  import init_seq_pkg::*;
#(
  parameter int RCV_RST_CYC   = 16,
  parameter int SER_RST_CYC   = 16,
  parameter int TRST_CYC      = 14,
  parameter int FE_RST_CYC    = 32,
  parameter int CLK_RST_CYC   = 4,
  parameter int LOCK_WAIT_CYC = 32_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cmd_code,
  input  logic       cmd_go,
  input  logic       use_prom,
  input  logic       prom_done,
  input  logic       clk_locked,
  input  logic       pll_lock,
  input  logic       phase_done,
  input  logic       phase_ok,
  output logic       rcv_rst_n,
  output logic       ser_rst_n,
  output logic       trst_n,
  output logic       fe_rst_n,
  output logic       clkmgr_rst,
  output logic       phase_req,
  output logic [3:0] state_code,
  output logic       err_flag
);
  localparam int unsigned MAX_CYC = max2(max2(max2(RCV_RST_CYC, SER_RST_CYC),
                                              max2(TRST_CYC, FE_RST_CYC)),
                                         max2(CLK_RST_CYC + 1, LOCK_WAIT_CYC));
  localparam int CNT_W = $clog2(MAX_CYC) + 1;

  state_e           state_q, nxt;
  logic             err_q, chain_q;
  logic             go_rise, step_done;
  logic             set_err, clr_err, set_chain, clr_chain;
  logic [CNT_W-1:0] cnt;

  init_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe(cmd_go), .rise(go_rise)
  );

  assign step_done = (nxt != state_q);

  init_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(step_done), .cnt(cnt)
  );

  init_next_state #(
    .CNT_W(CNT_W), .RCV_RST_CYC(RCV_RST_CYC), .SER_RST_CYC(SER_RST_CYC),
    .TRST_CYC(TRST_CYC), .FE_RST_CYC(FE_RST_CYC),
    .CLK_RST_CYC(CLK_RST_CYC), .LOCK_WAIT_CYC(LOCK_WAIT_CYC)
  ) u_next (
    .state(state_q), .cnt(cnt), .go_rise(go_rise), .cmd_code(cmd_code),
    .use_prom(use_prom), .chain(chain_q), .err(err_q),
    .prom_done(prom_done), .clk_locked(clk_locked), .pll_lock(pll_lock),
    .phase_done(phase_done), .phase_ok(phase_ok),
    .nxt(nxt), .set_err(set_err), .clr_err(clr_err),
    .set_chain(set_chain), .clr_chain(clr_chain)
  );

  // Power-up enters the receiver reset with the chain armed (R10, R14).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RCV_RST;
      chain_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      if (set_chain)      chain_q <= 1'b1;
      else if (clr_chain) chain_q <= 1'b0;
      if (set_err)        err_q <= 1'b1;
      else if (clr_err)   err_q <= 1'b0;
    end
  end

  assign rcv_rst_n  = ~((state_q == ST_RCV_RST) || (state_q == ST_RCV_LOAD));
  assign ser_rst_n  = (state_q != ST_SER_RST);
  assign trst_n     = (state_q != ST_TRST);
  assign fe_rst_n   = (state_q != ST_FE_RST);
  assign clkmgr_rst = (state_q == ST_CLK_RST) && (32'(cnt) < CLK_RST_CYC);
  assign phase_req  = (state_q == ST_PHASE);
  assign state_code = state_q;
  assign err_flag   = err_q;
endmodule

// File: rtl/init_seq_chk.sv
module init_seq_chk
  import init_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input state_e     state,
  input logic       go_rise,
  input logic       step_done,
  input logic [3:0] cmd_code,
  input logic       err_flag,
  input logic       pll_lock,
  input logic       phase_done,
  input logic       phase_ok,
  input logic       rcv_rst_n,
  input logic       ser_rst_n,
  input logic       trst_n,
  input logic       fe_rst_n,
  input logic       clkmgr_rst
);
  assert_accept_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && go_rise && cmd_code >= 4'd1 && cmd_code <= 4'd11)
      |=> (state == $past(cmd_code)));

  assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && go_rise && !step_done) |=> $stable(state));

  assert_unknown_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && go_rise && (cmd_code == 4'd0 || cmd_code >= 4'd12))
      |=> (state == ST_IDLE));

  assert_lock_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK_WAIT && pll_lock) |=> (state == ST_IDLE));

  assert_one_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rcv_rst_n, ~ser_rst_n, ~trst_n, ~fe_rst_n, clkmgr_rst}));

  assert_err_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PHASE && phase_done && !phase_ok) |=> err_flag);

  assert_err_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERR_RETRY && err_flag && phase_ok) |=> (!err_flag && state == ST_IDLE));

  assert_edge_once_R13: assert property (@(posedge clk) disable iff (!rst_n)
    go_rise |=> !go_rise);
endmodule

bind board_init_seq init_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .state(state_q), .go_rise(go_rise),
  .step_done(step_done), .cmd_code(cmd_code), .err_flag(err_flag),
  .pll_lock(pll_lock), .phase_done(phase_done), .phase_ok(phase_ok),
  .rcv_rst_n(rcv_rst_n), .ser_rst_n(ser_rst_n), .trst_n(trst_n),
  .fe_rst_n(fe_rst_n), .clkmgr_rst(clkmgr_rst)
);

// File: tb/board_init_seq_tb_top.sv
`timescale 1ns/1ps
module board_init_seq_tb_top;
  localparam int LOCK_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic cmd_go = 1'b0, use_prom = 1'b0, prom_done = 1'b1, clk_locked = 1'b1;
  logic pll_lock = 1'b0, phase_done = 1'b0, phase_ok = 1'b1;
  logic rcv_rst_n, ser_rst_n, trst_n, fe_rst_n, clkmgr_rst, phase_req, err_flag;
  logic [3:0] state_code;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  board_init_seq #(.LOCK_WAIT_CYC(LOCK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_go(cmd_go),
    .use_prom(use_prom), .prom_done(prom_done), .clk_locked(clk_locked),
    .pll_lock(pll_lock), .phase_done(phase_done), .phase_ok(phase_ok),
    .rcv_rst_n(rcv_rst_n), .ser_rst_n(ser_rst_n), .trst_n(trst_n),
    .fe_rst_n(fe_rst_n), .clkmgr_rst(clkmgr_rst), .phase_req(phase_req),
    .state_code(state_code), .err_flag(err_flag)
  );

  // {code, use_prom, first state, dwell, following state, output select}
  // select: 0 rcv, 1 ser, 2 trst, 3 fe, 4 clkmgr, 5 none
  localparam logic [23:0] VEC [10] = '{
    {4'd7,  1'b0, 4'd7,  8'd14, 4'd0,  3'd2},
    {4'd9,  1'b0, 4'd9,  8'd32, 4'd0,  3'd3},
    {4'd2,  1'b0, 4'd2,  8'd16, 4'd5,  3'd0},
    {4'd2,  1'b1, 4'd2,  8'd16, 4'd10, 3'd0},
    {4'd8,  1'b0, 4'd8,  8'd16, 4'd10, 3'd0},
    {4'd3,  1'b0, 4'd3,  8'd16, 4'd4,  3'd1},
    {4'd5,  1'b0, 4'd5,  8'd5,  4'd0,  3'd4},
    {4'd13, 1'b0, 4'd0,  8'd0,  4'd0,  3'd5},
    {4'd15, 1'b0, 4'd0,  8'd0,  4'd0,  3'd5},
    {4'd0,  1'b0, 4'd0,  8'd0,  4'd0,  3'd5}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string req_of(input int code);
    case (code)
      7, 9:    return "R8";
      2:       return "R4";
      8:       return "R9";
      3:       return "R6";
      5:       return "R5";
      default: return "R3";
    endcase
  endfunction

  function automatic int active(input int sel);
    case (sel)
      0: return int'(!rcv_rst_n);
      1: return int'(!ser_rst_n);
      2: return int'(!trst_n);
      3: return int'(!fe_rst_n);
      4: return int'(clkmgr_rst);
      default: return 0;
    endcase
  endfunction

  // Rising strobe at one falling edge; state is due by the next falling edge.
  task automatic issue(input int code, input bit hold);
    @(negedge clk);
    cmd_code = 4'(code);
    cmd_go = 1'b1;
    @(negedge clk);
    if (!hold) cmd_go = 1'b0;
  endtask

  task automatic dwell(input int st, output int n);
    n = 0;
    while (int'(state_code) == st && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && state_code != 4'd0; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    // R14: reset state
    repeat (3) @(negedge clk);
    chk("R14 state in reset", int'(state_code), 2);
    chk("R14 rcv_rst_n in reset", int'(rcv_rst_n), 0);
    chk("R14 other resets idle", int'({ser_rst_n, trst_n, fe_rst_n, clkmgr_rst}), 4'b1110);
    chk("R14 err in reset", int'(err_flag), 0);
    rst_n = 1'b1;
    // R10: power-up chain
    dwell(2, n);  chk("R10 R4 power-up receiver pulse", n, 16);
    chk("R10 to clock reset", int'(state_code), 5);
    dwell(5, n);  chk("R5 clock reset dwell", n, 5);
    chk("R10 chain to serialiser reset", int'(state_code), 3);
    dwell(3, n);  chk("R6 serialiser pulse", n, 16);
    chk("R6 to lock wait", int'(state_code), 4);
    dwell(4, n);  chk("R7 lock wait timeout", n, LOCK_W);
    chk("R10 chain ends idle", int'(state_code), 0);

    // table of commands
    foreach (VEC[i]) begin
      int code, exp_st, dw, nx, sel;
      code = int'(VEC[i][23:20]); use_prom = VEC[i][19];
      exp_st = int'(VEC[i][18:15]); dw = int'(VEC[i][14:7]);
      nx = int'(VEC[i][6:3]); sel = int'(VEC[i][2:0]);
      issue(code, 1'b0);
      chk({req_of(code), " R2 entered state"}, int'(state_code), exp_st);
      if (dw > 0) begin
        chk({req_of(code), " output active"}, active(sel), 1);
        dwell(exp_st, n);
        chk({req_of(code), " dwell"}, n, dw);
        chk({req_of(code), " following state"}, int'(state_code), nx);
        chk({req_of(code), " output released"}, active(sel), 0);
      end else begin
        repeat (3) @(negedge clk);
        chk("R3 stays idle", int'(state_code), 0);
      end
      wait_idle();
    end
    use_prom = 1'b0;

    // R10: FPGA reset command
    issue(1, 1'b0);
    chk("R10 FPGA reset state", int'(state_code), 1);
    dwell(1, n); chk("R10 FPGA reset one cycle", n, 1);
    chk("R10 then receiver reset", int'(state_code), 2);
    dwell(2, n); dwell(5, n);
    chk("R10 then serialiser reset", int'(state_code), 3);
    wait_idle();

    // R2: strobe while busy ignored
    issue(9, 1'b0);
    repeat (4) @(negedge clk);
    cmd_code = 4'd7; cmd_go = 1'b1;
    @(negedge clk); cmd_go = 1'b0;
    chk("R2 busy command ignored", int'(state_code), 9);
    dwell(9, n);
    chk("R2 after pulse idle not JTAG", int'(state_code), 0);
    chk("R8 front-end dwell remainder", n, 32 - 5);

    // R13: held strobe
    issue(7, 1'b1);
    dwell(7, n);
    repeat (5) @(negedge clk);
    chk("R13 held strobe gives one action", int'(state_code), 0);
    cmd_go = 1'b0;

    // R7: early lock
    pll_lock = 1'b1;
    issue(4, 1'b0);
    dwell(4, n);
    chk("R7 early lock dwell", n, 1);
    chk("R7 early lock to idle", int'(state_code), 0);
    pll_lock = 1'b0;

    // R5: PROM wait holds
    prom_done = 1'b0;
    issue(10, 1'b0);
    repeat (6) @(negedge clk);
    chk("R5 PROM wait holds", int'(state_code), 10);
    prom_done = 1'b1;
    @(negedge clk);
    chk("R5 PROM done to clock reset", int'(state_code), 5);
    chk("R5 clock reset active", int'(clkmgr_rst), 1);
    wait_idle();

    // R11: failed sampling
    phase_ok = 1'b0; phase_done = 1'b0;
    issue(6, 1'b0);
    chk("R11 phase request", int'(phase_req), 1);
    phase_done = 1'b1;
    @(negedge clk);
    phase_done = 1'b0;
    chk("R11 sample done to idle", int'(state_code), 0);
    chk("R11 error set", int'(err_flag), 1);

    // R12: retry with fault present
    issue(11, 1'b0);
    chk("R12 retry state", int'(state_code), 11);
    @(negedge clk);
    chk("R12 retry to sampling", int'(state_code), 6);
    chk("R12 error kept", int'(err_flag), 1);
    phase_ok = 1'b1; phase_done = 1'b1;
    @(negedge clk);
    phase_done = 1'b0;
    chk("R11 good sample keeps error", int'(err_flag), 1);
    issue(11, 1'b0);
    @(negedge clk);
    chk("R12 fault gone clears error", int'(err_flag), 0);
    chk("R12 retry to idle", int'(state_code), 0);
    chk("R1 idle resets inactive", int'({rcv_rst_n, ser_rst_n, trst_n, fe_rst_n, clkmgr_rst}), 5'b11110);

    finish_run();
  end
endmodule